// File: doc/BRIEF.md
# Audio Clock Divider Chain

This block derives the two clocks an audio serial port needs. The first is the codec master clock (MCLK) and the second is the serial bit clock (SCLK). Three source oscillators are presented as tick strobes on a common system clock. A 32-bit format control word selects one source and sets two divide ratios. MCLK passes one of every N ticks of the chosen source. SCLK passes one of every M MCLK ticks, so its rate relative to the source is N·M.

Each ratio is stored as an encoded field, not as a binary count. A small set of reserved codes stands for the ratios 1, 3, 5 and 14. Every other code c stands for the even ratio 2·(c+1). A master bit decides whether the block drives the bit clock. A reserved source selection raises an error flag and silences both clocks. When the control word changes, both counters restart from zero, so no short pulse is produced.

Each clock is given as a one-cycle tick strobe and as a level. The level has 50 % duty for even ratios. For odd ratios above 1, the high phase is one source tick shorter than the low phase.

Top module: `aclk_div_top`

## Requirements
- R1: While rst_ni is low and in the first cycle after release, mclk_tick_o and sclk_tick_o are low. cfg_err_o is low whenever ctrl_i[31:30] is not 3.
- R2: Only ticks of the source that ctrl_i[31:30] selects advance MCLK. Value 0 picks src_tick_i[0], value 1 picks src_tick_i[1] and value 2 picks src_tick_i[2]. Ticks on the other two inputs have no effect.
- R3: Source select value 3 is reserved. It sets cfg_err_o high, keeps mclk_o and sclk_o low, and produces no tick on either clock.
- R4: The MCLK code in ctrl_i[28:24] maps 0x14 to ratio 1, 0x13 to ratio 3, 0x12 to ratio 5 and 0x0E to ratio 14. mclk_tick_o pulses for one cycle in the cycle after every Nth selected source tick.
- R5: Any other MCLK code c gives the ratio 2·(c+1), which ranges from 2 to 64.
- R6: The SCLK code in ctrl_i[23:20] maps 8 to ratio 1 and 9 to ratio 3. Any other code c gives 2·(c+1). SCLK counts MCLK ticks, so sclk_tick_o pulses once per N·M selected source ticks and only in a cycle in which mclk_tick_o also pulses.
- R7: When ctrl_i[19] (master) is 0, sclk_tick_o and sclk_o stay low and MCLK is unaffected.
- R8: Any change of ctrl_i clears both counters in that cycle and drops a source tick arriving in that cycle. The first MCLK pulse after the change follows the Nth selected tick after the change cycle.
- R9: Sampled in the cycles that carry a selected tick, mclk_o is high for floor(N/2) of every N ticks when N > 1, and is always high when N = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 3 | Tick strobes of the three source oscillators |
| ctrl_i | input | 32 | Format control word |
| mclk_tick_o | output | 1 | One-cycle strobe per MCLK period |
| mclk_o | output | 1 | MCLK level |
| sclk_tick_o | output | 1 | One-cycle strobe per SCLK period |
| sclk_o | output | 1 | SCLK level |
| cfg_err_o | output | 1 | Reserved source selection in use |

## Verification
The test sweeps every MCLK code with SCLK set to ratio 1, which isolates the MCLK decoding. It then sweeps every SCLK code over MCLK ratio 3, which shows that SCLK counts MCLK ticks rather than source ticks. Random control words then combine both ratios, all three sources and both master settings. The two unselected source inputs carry random noise throughout, so a wrong source selection shows up as a wrong pulse count.

Windows whose length is a whole multiple of N·M separate the reserved codes from the even formula, and give exact duty counts for odd and even ratios. Directed cases cover four further situations:
- a control change in the middle of a count, with a tick arriving in the change cycle
- ticks only on unselected sources
- the reserved source value
- master cleared

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int NUM_SRC = 3;
  localparam int SEL_W   = 2;
  localparam int MCODE_W = 5;
  localparam int SCODE_W = 4;
  localparam int MR_W    = MCODE_W + 2;  // holds ratio up to 64
  localparam int SR_W    = SCODE_W + 2;  // holds ratio up to 32

  localparam int SEL_HI   = 31;
  localparam int MCODE_HI = 28;
  localparam int SCODE_HI = 23;
  localparam int MST_BIT  = 19;

  function automatic logic [MR_W-1:0] mclk_ratio(input logic [MCODE_W-1:0] c);
    case (c)
      5'h14:   mclk_ratio = MR_W'(1);
      5'h13:   mclk_ratio = MR_W'(3);
      5'h12:   mclk_ratio = MR_W'(5);
      5'h0E:   mclk_ratio = MR_W'(14);
      default: mclk_ratio = (MR_W'(c) + MR_W'(1)) << 1;
    endcase
  endfunction

  function automatic logic [SR_W-1:0] sclk_ratio(input logic [SCODE_W-1:0] c);
    case (c)
      4'h8:    sclk_ratio = SR_W'(1);
      4'h9:    sclk_ratio = SR_W'(3);
      default: sclk_ratio = (SR_W'(c) + SR_W'(1)) << 1;
    endcase
  endfunction
endpackage

// File: rtl/aclk_src_mux.sv
module aclk_src_mux #(
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               tick_o,
  output logic               err_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign hit[g] = src_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
  assign err_o  = (int'(sel_i) >= NUM_SRC);
endmodule

// File: rtl/aclk_ratio_div.sv
module aclk_ratio_div #(
  parameter int RW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [RW-1:0] ratio_i,
  output logic          wrap_o,
  output logic          lvl_o
);
  logic [RW-1:0] cnt_q;
  logic          last;

  assign last   = cnt_q >= (ratio_i - RW'(1));
  assign wrap_o = en_i && last && !clr_i;
  // high phase is floor(N/2) ticks; N=1 stays high
  assign lvl_o  = (ratio_i == RW'(1)) ? 1'b1 : (cnt_q < (ratio_i >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (en_i)     cnt_q <= last ? '0 : cnt_q + RW'(1);
  end
endmodule

// File: rtl/aclk_div_top.sv
module aclk_div_top
  import aclk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  src_tick_i,
  input  logic [31:0]         ctrl_i,
  output logic                mclk_tick_o,
  output logic                mclk_o,
  output logic                sclk_tick_o,
  output logic                sclk_o,
  output logic                cfg_err_o
);
  logic [31:0]      ctrl_q;
  logic             chg, err, src_tick, clr;
  logic             m_wrap, m_lvl, s_wrap, s_lvl, master;
  logic             mtick_q, stick_q;
  logic [MR_W-1:0]  m_ratio;
  logic [SR_W-1:0]  s_ratio;

  assign chg     = ctrl_i != ctrl_q;
  assign master  = ctrl_i[MST_BIT];
  assign m_ratio = mclk_ratio(ctrl_i[MCODE_HI -: MCODE_W]);
  assign s_ratio = sclk_ratio(ctrl_i[SCODE_HI -: SCODE_W]);
  assign clr     = chg || err;

  aclk_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_i  (src_tick_i),
    .sel_i  (ctrl_i[SEL_HI -: SEL_W]),
    .tick_o (src_tick),
    .err_o  (err)
  );

  aclk_ratio_div #(.RW(MR_W)) u_mdiv (
    .clk_i, .rst_ni,
    .clr_i   (clr),
    .en_i    (src_tick),
    .ratio_i (m_ratio),
    .wrap_o  (m_wrap),
    .lvl_o   (m_lvl)
  );

  // SCLK counts MCLK periods
  aclk_ratio_div #(.RW(SR_W)) u_sdiv (
    .clk_i, .rst_ni,
    .clr_i   (clr),
    .en_i    (m_wrap),
    .ratio_i (s_ratio),
    .wrap_o  (s_wrap),
    .lvl_o   (s_lvl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      mtick_q <= 1'b0;
      stick_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_i;
      mtick_q <= m_wrap;
      stick_q <= s_wrap && master;
    end
  end

  assign mclk_tick_o = mtick_q;
  assign sclk_tick_o = stick_q;
  assign mclk_o      = m_lvl && !err;
  assign sclk_o      = s_lvl && !err && master;
  assign cfg_err_o   = err;
endmodule

// File: rtl/aclk_div_chk.sv
module aclk_div_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  src_tick_i,
  input logic [31:0] ctrl_i,
  input logic        mclk_tick_o,
  input logic        mclk_o,
  input logic        sclk_tick_o,
  input logic        sclk_o,
  input logic        cfg_err_o
);
  a_r3_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> !mclk_tick_o && !sclk_tick_o);

  a_r3_err_levels: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !mclk_o && !sclk_o);

  a_r2_no_src_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_tick_i == 3'b000) |=> !mclk_tick_o);

  a_r6_sclk_on_mclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_tick_o |-> mclk_tick_o);

  a_r7_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[19] |=> !sclk_tick_o);

  a_r8_change_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i != $past(ctrl_i)) |=> !mclk_tick_o);
endmodule

bind aclk_div_top aclk_div_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_tick_i  (src_tick_i),
  .ctrl_i      (ctrl_i),
  .mclk_tick_o (mclk_tick_o),
  .mclk_o      (mclk_o),
  .sclk_tick_o (sclk_tick_o),
  .sclk_o      (sclk_o),
  .cfg_err_o   (cfg_err_o)
);

// File: tb/aclk_div_top_tb_top.sv
module aclk_div_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  src_tick_i = '0;
  logic [31:0] ctrl_i = '0;
  logic        mclk_tick_o, mclk_o, sclk_tick_o, sclk_o, cfg_err_o;

  int checks = 0, fails = 0;
  int cnt_m, cnt_s, hi_m, err_seen, lvl_bad, sel_cur;
  int cycles = 0;

  always #4 clk_i = ~clk_i;

  aclk_div_top dut_i (.*);

  function automatic int exp_m(input logic [4:0] c);
    case (c)
      5'h14: return 1;
      5'h13: return 3;
      5'h12: return 5;
      5'h0E: return 14;
      default: return 2 * (int'(c) + 1);
    endcase
  endfunction

  function automatic int exp_s(input logic [3:0] c);
    if (c == 4'h8) return 1;
    if (c == 4'h9) return 3;
    return 2 * (int'(c) + 1);
  endfunction

  function automatic logic [31:0] mk(input logic [1:0] sel, input logic [4:0] mc,
                                     input logic [3:0] sc, input logic mst);
    logic [18:0] fill = 19'($urandom);
    return {sel, 1'b0, mc, sc, mst, fill};
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] t);
    @(negedge clk_i);
    if (mclk_tick_o) cnt_m++;
    if (sclk_tick_o) cnt_s++;
    if (cfg_err_o) err_seen++;
    if (cfg_err_o && (mclk_o || sclk_o)) lvl_bad++;
    src_tick_i = t;
    if (sel_cur < 3 && t[sel_cur] && mclk_o) hi_m++;
  endtask

  task automatic clr_cnt();
    cnt_m = 0; cnt_s = 0; hi_m = 0; err_seen = 0; lvl_bad = 0;
  endtask

  task automatic apply(input logic [31:0] v);
    @(negedge clk_i);
    ctrl_i = v;
    src_tick_i = '0;
    sel_cur = int'(v[31:30]);
    step(3'b000);
    step(3'b000);
    clr_cnt();
  endtask

  // window of K*N*M selected ticks with random noise on other sources
  task automatic win(input logic [31:0] v, input int k);
    int nm, ns, w, given;
    logic [2:0] t;
    nm = exp_m(v[28:24]);
    ns = exp_s(v[23:20]);
    w = k * nm * ns;
    apply(v);
    given = 0;
    while (given < w) begin
      t = 3'($urandom);
      t[sel_cur] = ($urandom % 3) != 0;
      step(t);
      if (t[sel_cur]) given++;
    end
    for (int i = 0; i < 3; i++) step(3'b000);
    chk(cnt_m, w / nm, $sformatf("R4/R5 mclk count code %0h", v[28:24]));
    chk(cnt_s, v[19] ? w / (nm * ns) : 0,
        $sformatf("R6/R7 sclk count m %0h s %0h mst %0d", v[28:24], v[23:20], v[19]));
    chk(hi_m, (nm == 1) ? w : (w / nm) * (nm / 2),
        $sformatf("R9 mclk high samples ratio %0d", nm));
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 190000) begin
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h1234_abcd));
    sel_cur = 0;
    clr_cnt();
    ctrl_i = mk(2'd0, 5'h14, 4'h8, 1'b1);
    src_tick_i = 3'b111;
    repeat (3) @(negedge clk_i);
    chk(int'(mclk_tick_o) + int'(sclk_tick_o) + int'(cfg_err_o), 0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(int'(mclk_tick_o) + int'(sclk_tick_o), 0, "R1 first cycle out of reset");
    src_tick_i = '0;

    // R4 R5: every MCLK code, SCLK ratio 1
    for (int c = 0; c < 32; c++)
      win(mk(2'(c % 3), 5'(c), 4'h8, 1'b1), 3);

    // R6: every SCLK code over MCLK ratio 3
    for (int c = 0; c < 16; c++)
      win(mk(2'(c % 3), 5'h13, 4'(c), 1'b1), 2);

    // R7: master cleared
    win(mk(2'd1, 5'h01, 4'h9, 1'b0), 3);
    chk(err_seen, 0, "R1 no error for valid source");

    // random combinations
    for (int i = 0; i < 8; i++) begin
      v = mk(2'($urandom % 3), 5'($urandom), 4'($urandom), 1'($urandom));
      win(v, 1);
    end

    // R2: only unselected sources tick
    apply(mk(2'd1, 5'h13, 4'h8, 1'b1));
    for (int i = 0; i < 60; i++) step(3'b101);
    step(3'b000);
    chk(cnt_m, 0, "R2 unselected sources ignored");

    // R3: reserved source select
    apply(mk(2'd3, 5'h14, 4'h8, 1'b1));
    for (int i = 0; i < 50; i++) step(3'b111);
    step(3'b000);
    chk(cnt_m + cnt_s, 0, "R3 no ticks when reserved");
    chk(err_seen, 51, "R3 error flag held");
    chk(lvl_bad, 0, "R3 levels low when reserved");

    // R8: change mid-count, tick in change cycle dropped
    apply(mk(2'd0, 5'h0E, 4'h8, 1'b1));
    for (int i = 0; i < 5; i++) step(3'b001);
    @(negedge clk_i);
    if (mclk_tick_o) cnt_m++;
    ctrl_i = mk(2'd0, 5'h02, 4'h8, 1'b1);  // ratio 6
    src_tick_i = 3'b001;                   // arrives in change cycle
    for (int i = 0; i < 5; i++) step(3'b001);
    step(3'b000);
    step(3'b000);
    chk(cnt_m, 0, "R8 no pulse before 6 ticks after change");
    step(3'b001);
    step(3'b000);
    step(3'b000);
    chk(cnt_m, 1, "R8 first pulse after 6th tick");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule